// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits beside a processor running in its large-system configuration, where the processor reports each bus cycle only as a three-bit status code. The controller watches that code, notices when a new bus cycle begins, and produces the system control bus for the cycle. It drives separate memory and I/O read and write strobes, an interrupt acknowledge strobe, and early-asserting write strobes for slower devices. It also drives the address latch strobe, and the enable and direction lines for the external data transceiver.

The cycle runs through four clock phases, T1 to T4, counted from the clock edge that sees the status leave the passive code. Read-type strobes cover T2 to T4. The normal write strobes cover T3 to T4. The early write strobes cover T2 to T4. Two enable inputs gate the strobes as they leave the block. A mode input lets the I/O-side strobes run on a private I/O bus that is not subject to the address enable.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: The status code 3'b111 is passive. When the block is idle, a clock edge that sees a non-passive code, after the previous edge saw the passive code, starts a cycle. The cycle's T1 follows that edge, and `addr_strobe_o` is high for exactly that one clock.
- R2: The code latched at the start of the cycle selects the strobes. 3'b000 selects interrupt acknowledge. 3'b001 selects I/O read. 3'b010 selects I/O write plus the early I/O write. 3'b011 is halt. 3'b100 (instruction fetch) and 3'b101 both select memory read. 3'b110 selects memory write plus the early memory write.
- R3: At most one of memory read, memory write, I/O read, I/O write and interrupt acknowledge is high at any time.
- R4: Memory read, I/O read and interrupt acknowledge are high in T2, T3 and T4. Memory write and I/O write are high only in T3 and T4.
- R5: The early memory write and early I/O write are high in T2, T3 and T4, so they lead the matching normal write by one clock.
- R6: `data_en_o` is high in T2 to T4 of every cycle except halt. `data_dir_o` is 1 (transmit) in T1 to T4 of write cycles (3'b010, 3'b110) and 0 otherwise. Transmit never coincides with a read strobe.
- R7: A halt cycle and the idle state produce no strobe and no data enable.
- R8: While `cmd_en_i` is low, every strobe and `data_en_o` are low. This gating acts in the same clock in which the input changes.
- R9: While `addr_en_i` is low, the memory strobes are low. The I/O strobes and interrupt acknowledge are also low unless `io_bus_i` is high.
- R10: While `io_bus_i` is high, the I/O strobes and interrupt acknowledge follow R4 and R5 whatever the level of `addr_en_i`.
- R11: A status code that stays non-passive past T4 does not start a new cycle. A new cycle needs the passive code to be seen first.
- R12: While `rst_n` is low (asynchronous), every output is low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| status_i | input | 3 | Bus-cycle status code from the processor |
| cmd_en_i | input | 1 | Command enable, low forces all strobes off |
| addr_en_i | input | 1 | Address enable, gates strobes onto the system bus |
| io_bus_i | input | 1 | High: I/O strobes bypass the address enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| adv_mem_wr_o | output | 1 | Early memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| adv_io_wr_o | output | 1 | Early I/O write strobe |
| int_ack_o | output | 1 | Interrupt acknowledge strobe |
| addr_strobe_o | output | 1 | Address latch strobe, high in T1 |
| data_en_o | output | 1 | Data transceiver enable |
| data_dir_o | output | 1 | Data transceiver direction, 1 = transmit |

## Verification
On every clock, the assertions check the following. The five main strobes are mutually exclusive. Each normal write rises one clock after its early write when the enables are steady. A low command enable or address enable blanks the strobes it governs. Halt cycles stay quiet. The address strobe is a single-clock pulse following each cycle start. The transmit direction never overlaps a read. What only the bench scenarios show is the exact phase window of each strobe for every status code and enable combination. The bench scenarios also show that a status held active past T4 does not start a new cycle, that a mid-cycle change of the command enable takes effect in the same clock, and that a reset in the middle of a cycle clears the outputs.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

  localparam int ST_W    = 3;
  localparam int PHASE_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_INTA    = 3'b000,
    ST_IORD    = 3'b001,
    ST_IOWR    = 3'b010,
    ST_HALT    = 3'b011,
    ST_FETCH   = 3'b100,
    ST_MRD     = 3'b101,
    ST_MWR     = 3'b110,
    ST_PASSIVE = 3'b111
  } bus_status_e;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_T4   = 3'd4
  } phase_e;

  typedef struct packed {
    logic int_ack;
    logic adv_io_wr;
    logic adv_mem_wr;
    logic io_wr;
    logic io_rd;
    logic mem_wr;
    logic mem_rd;
  } cmd_t;

  function automatic logic is_passive(input bus_status_e c);
    return c == ST_PASSIVE;
  endfunction

  function automatic logic is_mem_read(input bus_status_e c);
    return (c == ST_FETCH) || (c == ST_MRD);
  endfunction

  function automatic logic is_mem_write(input bus_status_e c);
    return c == ST_MWR;
  endfunction

  function automatic logic is_io_read(input bus_status_e c);
    return c == ST_IORD;
  endfunction

  function automatic logic is_io_write(input bus_status_e c);
    return c == ST_IOWR;
  endfunction

  function automatic logic is_inta(input bus_status_e c);
    return c == ST_INTA;
  endfunction

  function automatic logic is_write(input bus_status_e c);
    return is_mem_write(c) || is_io_write(c);
  endfunction

  // Codes that move data across the transceiver
  function automatic logic moves_data(input bus_status_e c);
    return !is_passive(c) && (c != ST_HALT);
  endfunction

  // Phase windows: early covers T2..T4, late covers T3..T4
  function automatic logic in_early(input phase_e p);
    return (p == PH_T2) || (p == PH_T3) || (p == PH_T4);
  endfunction

  function automatic logic in_late(input phase_e p);
    return (p == PH_T3) || (p == PH_T4);
  endfunction

  function automatic logic in_cycle(input phase_e p);
    return p != PH_IDLE;
  endfunction

endpackage

// File: rtl/bcc_cycle_tracker.sv
module bcc_cycle_tracker
  import bcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] status_i,
  output phase_e          phase_o,
  output bus_status_e     code_o,
  output logic            start_o
);

  bus_status_e status_now;
  logic        prev_passive_q;
  phase_e      phase_q;
  bus_status_e code_q;

  assign status_now = bus_status_e'(status_i);

  // A cycle begins only from idle, on a passive-to-active change
  assign start_o = (phase_q == PH_IDLE) && prev_passive_q && !is_passive(status_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_passive_q <= 1'b1;
      phase_q        <= PH_IDLE;
      code_q         <= ST_PASSIVE;
    end else begin
      prev_passive_q <= is_passive(status_now);
      unique case (phase_q)
        PH_IDLE: begin
          if (start_o) begin
            phase_q <= PH_T1;
            code_q  <= status_now;
          end
        end
        PH_T1: phase_q <= PH_T2;
        PH_T2: phase_q <= PH_T3;
        PH_T3: phase_q <= PH_T4;
        PH_T4: begin
          phase_q <= PH_IDLE;
          code_q  <= ST_PASSIVE;
        end
        default: begin
          phase_q <= PH_IDLE;
          code_q  <= ST_PASSIVE;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign code_o  = code_q;

endmodule

// File: rtl/bcc_cmd_decode.sv
module bcc_cmd_decode
  import bcc_pkg::*;
(
  input  phase_e      phase_i,
  input  bus_status_e code_i,
  output cmd_t        raw_cmd_o,
  output logic        strobe_o,
  output logic        den_raw_o,
  output logic        dir_o
);

  logic early_w;
  logic late_w;
  logic live_w;

  assign early_w = in_early(phase_i);
  assign late_w  = in_late(phase_i);
  assign live_w  = in_cycle(phase_i);

  always_comb begin
    raw_cmd_o            = '0;
    raw_cmd_o.mem_rd     = early_w && is_mem_read(code_i);
    raw_cmd_o.io_rd      = early_w && is_io_read(code_i);
    raw_cmd_o.int_ack    = early_w && is_inta(code_i);
    raw_cmd_o.adv_mem_wr = early_w && is_mem_write(code_i);
    raw_cmd_o.adv_io_wr  = early_w && is_io_write(code_i);
    raw_cmd_o.mem_wr     = late_w  && is_mem_write(code_i);
    raw_cmd_o.io_wr      = late_w  && is_io_write(code_i);
  end

  assign strobe_o  = (phase_i == PH_T1);
  assign den_raw_o = early_w && moves_data(code_i);
  assign dir_o     = live_w && is_write(code_i);

endmodule

// File: rtl/bcc_out_gate.sv
module bcc_out_gate
  import bcc_pkg::*;
(
  input  cmd_t raw_cmd_i,
  input  logic den_raw_i,
  input  logic cmd_en_i,
  input  logic addr_en_i,
  input  logic io_bus_i,
  output cmd_t cmd_o,
  output logic den_o
);

  logic mem_ok_w;
  logic io_ok_w;

  assign mem_ok_w = cmd_en_i && addr_en_i;
  assign io_ok_w  = cmd_en_i && (addr_en_i || io_bus_i);

  always_comb begin
    cmd_o            = '0;
    cmd_o.mem_rd     = raw_cmd_i.mem_rd     && mem_ok_w;
    cmd_o.mem_wr     = raw_cmd_i.mem_wr     && mem_ok_w;
    cmd_o.adv_mem_wr = raw_cmd_i.adv_mem_wr && mem_ok_w;
    cmd_o.io_rd      = raw_cmd_i.io_rd      && io_ok_w;
    cmd_o.io_wr      = raw_cmd_i.io_wr      && io_ok_w;
    cmd_o.adv_io_wr  = raw_cmd_i.adv_io_wr  && io_ok_w;
    cmd_o.int_ack    = raw_cmd_i.int_ack    && io_ok_w;
  end

  assign den_o = den_raw_i && cmd_en_i;

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
  import bcc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] status_i,
  input  logic            cmd_en_i,
  input  logic            addr_en_i,
  input  logic            io_bus_i,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic            adv_mem_wr_o,
  output logic            io_rd_o,
  output logic            io_wr_o,
  output logic            adv_io_wr_o,
  output logic            int_ack_o,
  output logic            addr_strobe_o,
  output logic            data_en_o,
  output logic            data_dir_o
);

  phase_e      phase_w;
  bus_status_e cyc_code_w;
  logic        cyc_start_w;
  cmd_t        raw_cmd_w;
  cmd_t        gated_cmd_w;
  logic        den_raw_w;
  logic        raw_io_rd_w;

  bcc_cycle_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_i),
    .phase_o  (phase_w),
    .code_o   (cyc_code_w),
    .start_o  (cyc_start_w)
  );

  bcc_cmd_decode u_dec (
    .phase_i   (phase_w),
    .code_i    (cyc_code_w),
    .raw_cmd_o (raw_cmd_w),
    .strobe_o  (addr_strobe_o),
    .den_raw_o (den_raw_w),
    .dir_o     (data_dir_o)
  );

  bcc_out_gate u_gate (
    .raw_cmd_i (raw_cmd_w),
    .den_raw_i (den_raw_w),
    .cmd_en_i  (cmd_en_i),
    .addr_en_i (addr_en_i),
    .io_bus_i  (io_bus_i),
    .cmd_o     (gated_cmd_w),
    .den_o     (data_en_o)
  );

  assign raw_io_rd_w  = raw_cmd_w.io_rd;

  assign mem_rd_o     = gated_cmd_w.mem_rd;
  assign mem_wr_o     = gated_cmd_w.mem_wr;
  assign adv_mem_wr_o = gated_cmd_w.adv_mem_wr;
  assign io_rd_o      = gated_cmd_w.io_rd;
  assign io_wr_o      = gated_cmd_w.io_wr;
  assign adv_io_wr_o  = gated_cmd_w.adv_io_wr;
  assign int_ack_o    = gated_cmd_w.int_ack;

endmodule

// File: rtl/bus_cmd_ctrl_chk.sv
module bus_cmd_ctrl_chk
  import bcc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_en_i,
  input logic        addr_en_i,
  input logic        io_bus_i,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        adv_mem_wr_o,
  input logic        io_rd_o,
  input logic        io_wr_o,
  input logic        adv_io_wr_o,
  input logic        int_ack_o,
  input logic        addr_strobe_o,
  input logic        data_en_o,
  input logic        data_dir_o,
  input bus_status_e cyc_code_w,
  input logic        cyc_start_w,
  input logic        raw_io_rd_w
);

  logic any_cmd;
  assign any_cmd = mem_rd_o || mem_wr_o || adv_mem_wr_o || io_rd_o ||
                   io_wr_o || adv_io_wr_o || int_ack_o;

  assert_strobe_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_w |=> addr_strobe_o);

  assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe_o |=> !addr_strobe_o);

  assert_one_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o, int_ack_o}));

  assert_mem_adv_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_wr_o) && $stable(cmd_en_i) && $stable(addr_en_i)) |-> $past(adv_mem_wr_o));

  assert_io_adv_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(io_wr_o) && $stable(cmd_en_i) && $stable(addr_en_i) && $stable(io_bus_i))
      |-> $past(adv_io_wr_o));

  assert_dir_not_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_dir_o |-> !(mem_rd_o || io_rd_o || int_ack_o));

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_code_w == ST_HALT) |-> (!any_cmd && !data_en_o));

  assert_cmd_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en_i |-> (!any_cmd && !data_en_o));

  assert_addr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_en_i |-> !(mem_rd_o || mem_wr_o || adv_mem_wr_o));

  assert_iob_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_io_rd_w && cmd_en_i && io_bus_i) |-> io_rd_o);

endmodule

bind bus_cmd_ctrl bus_cmd_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_en_i      (cmd_en_i),
  .addr_en_i     (addr_en_i),
  .io_bus_i      (io_bus_i),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .adv_mem_wr_o  (adv_mem_wr_o),
  .io_rd_o       (io_rd_o),
  .io_wr_o       (io_wr_o),
  .adv_io_wr_o   (adv_io_wr_o),
  .int_ack_o     (int_ack_o),
  .addr_strobe_o (addr_strobe_o),
  .data_en_o     (data_en_o),
  .data_dir_o    (data_dir_o),
  .cyc_code_w    (cyc_code_w),
  .cyc_start_w   (cyc_start_w),
  .raw_io_rd_w   (raw_io_rd_w)
);

// File: tb/sim_bus_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_bus_cmd_ctrl;

  localparam logic [2:0] PASS = 3'b111;
  localparam int NVEC = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] status = PASS;
  logic cen = 1'b1, aen = 1'b1, iob = 1'b0;
  logic mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack;
  logic strobe, den, dir;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bus_cmd_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .status_i(status),
    .cmd_en_i(cen), .addr_en_i(aen), .io_bus_i(iob),
    .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .adv_mem_wr_o(adv_mem_wr),
    .io_rd_o(io_rd), .io_wr_o(io_wr), .adv_io_wr_o(adv_io_wr),
    .int_ack_o(int_ack), .addr_strobe_o(strobe),
    .data_en_o(den), .data_dir_o(dir)
  );

  // Vector: {code, aen, cen, iob, full strobe set}
  // Strobe set bits: [6] int_ack [5] adv_io_wr [4] adv_mem_wr [3] io_wr [2] io_rd [1] mem_wr [0] mem_rd
  localparam logic [12:0] VEC [NVEC] = '{
    {3'b101, 1'b1, 1'b1, 1'b0, 7'b0000001},  // R2 R4 memory read
    {3'b100, 1'b1, 1'b1, 1'b0, 7'b0000001},  // R2 fetch
    {3'b110, 1'b1, 1'b1, 1'b0, 7'b0010010},  // R2 R5 memory write
    {3'b001, 1'b1, 1'b1, 1'b0, 7'b0000100},  // R2 I/O read
    {3'b010, 1'b1, 1'b1, 1'b0, 7'b0101000},  // R2 R5 I/O write
    {3'b000, 1'b1, 1'b1, 1'b0, 7'b1000000},  // R2 interrupt acknowledge
    {3'b011, 1'b1, 1'b1, 1'b0, 7'b0000000},  // R7 halt
    {3'b110, 1'b0, 1'b1, 1'b0, 7'b0000000},  // R9 memory write blocked
    {3'b001, 1'b0, 1'b1, 1'b1, 7'b0000100},  // R10 I/O read bypass
    {3'b010, 1'b0, 1'b1, 1'b1, 7'b0101000},  // R10 I/O write bypass
    {3'b101, 1'b0, 1'b1, 1'b1, 7'b0000000},  // R9 memory still blocked
    {3'b000, 1'b0, 1'b1, 1'b0, 7'b0000000},  // R9 ack blocked
    {3'b101, 1'b1, 1'b0, 1'b0, 7'b0000000},  // R8 command enable low
    {3'b010, 1'b1, 1'b0, 1'b1, 7'b0000000},  // R8 command enable low
    {3'b000, 1'b0, 1'b1, 1'b1, 7'b1000000}   // R10 ack bypass
  };

  function automatic logic [9:0] observed();
    return {int_ack, adv_io_wr, adv_mem_wr, io_wr, io_rd, mem_wr, mem_rd, strobe, den, dir};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // One full bus cycle checked phase by phase against the bench's own model
  task automatic run_vec(input logic [12:0] v, input string tag);
    logic [2:0] code;
    logic [6:0] full;
    logic moves, wr, e_den;
    code  = v[12:10];
    full  = v[6:0];
    moves = (code != 3'b011) && (code != PASS);
    wr    = (code == 3'b010) || (code == 3'b110);
    e_den = moves && v[8];
    @(negedge clk);
    status = PASS; aen = v[9]; cen = v[8]; iob = v[7];
    @(negedge clk);
    status = code;
    @(negedge clk); #1;
    check({tag, " T1"}, observed(), {7'b0, 1'b1, 1'b0, wr});
    status = PASS;
    @(negedge clk); #1;
    check({tag, " T2"}, observed(), {full & ~7'b0001010, 1'b0, e_den, wr});
    @(negedge clk); #1;
    check({tag, " T3"}, observed(), {full, 1'b0, e_den, wr});
    @(negedge clk); #1;
    check({tag, " T4"}, observed(), {full, 1'b0, e_den, wr});
    @(negedge clk); #1;
    check({tag, " idle R7"}, observed(), 10'b0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R12 reset state
    repeat (2) @(negedge clk);
    #1;
    check("R12 reset", observed(), 10'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], $sformatf("R2 vec %0d", i));

    // R11: status held active past T4 must not restart
    @(negedge clk);
    status = PASS; aen = 1'b1; cen = 1'b1; iob = 1'b0;
    @(negedge clk);
    status = 3'b101;
    repeat (4) @(negedge clk);
    @(negedge clk); #1;
    check("R11 held idle a", observed(), 10'b0);
    @(negedge clk); #1;
    check("R11 held idle b", observed(), 10'b0);
    status = PASS;
    @(negedge clk);
    status = 3'b101;
    @(negedge clk); #1;
    check("R1 restart strobe", observed(), {7'b0, 1'b1, 1'b0, 1'b0});
    status = PASS;
    repeat (4) @(negedge clk);

    // R8: command enable dropped mid-cycle acts at once
    @(negedge clk);
    status = 3'b001;
    @(negedge clk);
    status = PASS;
    @(negedge clk); #1;
    check("R4 io read T2", observed(), {7'b0000100, 1'b0, 1'b1, 1'b0});
    @(negedge clk);
    cen = 1'b0; #1;
    check("R8 mid-cycle off", observed(), 10'b0);
    @(negedge clk);
    cen = 1'b1; #1;
    check("R8 mid-cycle on", observed(), {7'b0000100, 1'b0, 1'b1, 1'b0});
    repeat (2) @(negedge clk);

    // R12: reset during a write cycle
    @(negedge clk);
    status = 3'b110;
    @(negedge clk);
    status = PASS;
    @(negedge clk);
    @(negedge clk); #1;
    check("R4 mem write T3", observed(), {7'b0010010, 1'b0, 1'b1, 1'b1});
    rst_n = 1'b0; #1;
    check("R12 mid-cycle reset", observed(), 10'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R12 idle after reset", observed(), 10'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule